// File: doc/BRIEF.md
# Age-Based True LRU Replacement for One Set

This block keeps the exact recency order of every way in one N-way associative set. A small fully associative translation buffer is a typical user. Each way holds an age: 0 is the most recently used way and N-1 is the least recently used. Together the ages always form a permutation of 0..N-1. The surrounding logic does the tag compare and the data storage.

The surrounding logic reports hits with a touch strobe and a way index. It also presents the valid bit of each way. On a miss it raises a fill request. The block always drives a victim way, combinationally, from the current ages and valid bits. When several ways are invalid, the lowest-numbered invalid way wins. When every way is valid, the oldest way is chosen.

A touch or a fill makes the target way the youngest. Ways younger than the target each age by one, and older ways keep their age. When the way count is two, the ages are stored as a single bit that names the least recently used way.

Top module: `age_lru_set`

## Requirements
- R1: During reset, way w is loaded with age w. After reset with all ways valid and no strobe, the victim is way WAYS-1.
- R2: When at least one bit of `way_valid` is 0, `victim_way` is the lowest index whose valid bit is 0, whatever the ages are.
- R3: When all bits of `way_valid` are 1, `victim_way` is the way with age WAYS-1, i.e. the least recently used way.
- R4: A touch of way t (with `fill_req` low) makes t the most recently used way. The relative order of all other ways stays the same.
- R5: A fill makes the way shown on `victim_way` in that cycle the most recently used way. The other ways keep their relative order.
- R6: When `touch_valid` and `fill_req` are both high, the fill alone updates the order. The victim is taken from the state before the edge, and the touched way is not promoted.
- R7: In a cycle with neither strobe, the order does not change, so with stable valid bits `victim_way` stays stable.
- R8: The set of ages is a permutation of 0..WAYS-1 at every clock edge after reset.
- R9: With WAYS=2, the order is held in one bit. The victim is the way not used most recently, and the reset victim is way 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| touch_valid | input | 1 | Hit strobe: promote `touch_way` |
| touch_way | input | $clog2(WAYS) | Index of the hit way |
| fill_req | input | 1 | Fill strobe: promote the current victim |
| way_valid | input | WAYS | Valid bit per way |
| victim_way | output | $clog2(WAYS) | Way to replace on the next fill |

## Verification
The assertions assume that `touch_way` always names an existing way. They also assume that `way_valid` may change in any cycle, and that both strobes may rise together. The stimulus draws touch indices only within 0..WAYS-1 and changes valid patterns freely. It includes cycles that raise touch and fill together, so the fill-priority path runs under the same invariants.

// File: rtl/lru_pkg.sv
package lru_pkg;

    typedef enum logic [1:0] {
        UPD_NONE  = 2'd0,
        UPD_TOUCH = 2'd1,
        UPD_FILL  = 2'd2
    } upd_kind_e;

    // Fill outranks touch when both strobes are high.
    function automatic upd_kind_e pick_kind(input logic touch, input logic fill);
        if (fill)
            return UPD_FILL;
        else if (touch)
            return UPD_TOUCH;
        return UPD_NONE;
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lru_age_victim.sv
module lru_age_victim
    import lru_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int AW   = idx_width(WAYS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [WAYS-1:0][AW-1:0] age_q,
    input  logic [WAYS-1:0]        way_valid,
    output logic [AW-1:0]          victim
);
    localparam logic [AW-1:0] OLDEST = AW'(WAYS - 1);

    logic          any_invalid;
    logic [AW-1:0] inv_idx;
    logic [AW-1:0] old_idx;

    // Lowest-numbered invalid way: scan downward so the last hit is the lowest index.
    always_comb begin
        inv_idx = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w])
                inv_idx = AW'(w);
        end
    end

    // Oldest way: exactly one way carries the top age.
    always_comb begin
        old_idx = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[w] == OLDEST)
                old_idx = AW'(w);
        end
    end

    assign any_invalid = ~&way_valid;
    assign victim      = any_invalid ? inv_idx : old_idx;

    // R2: an invalid way is always preferred over age order.
    assert_invalid_first_R2: assert property (@(posedge clk) disable iff (rst)
        any_invalid |-> !way_valid[victim]);

endmodule

// File: rtl/lru_age_update.sv
module lru_age_update
    import lru_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int AW   = idx_width(WAYS)
) (
    input  logic [WAYS-1:0][AW-1:0] age_q,
    input  upd_kind_e              kind,
    input  logic [AW-1:0]          touch_way,
    input  logic [AW-1:0]          victim,
    output logic                   upd_en,
    output logic [WAYS-1:0][AW-1:0] age_d
);
    logic [AW-1:0] target;
    logic [AW-1:0] target_age;

    assign target     = (kind == UPD_FILL) ? victim : touch_way;
    assign target_age = age_q[target];
    assign upd_en     = (kind != UPD_NONE);

    // Promote the target to age 0. Only younger ways shift back by one,
    // so the relative order of every other way is kept.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            if (AW'(w) == target)
                age_d[w] = '0;
            else if (age_q[w] < target_age)
                age_d[w] = age_q[w] + AW'(1);
            else
                age_d[w] = age_q[w];
        end
    end

endmodule

// File: rtl/lru_age_store.sv
module lru_age_store
    import lru_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int AW   = idx_width(WAYS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   upd_en,
    input  logic [WAYS-1:0][AW-1:0] age_d,
    output logic [WAYS-1:0][AW-1:0] age_q
);
    generate
        if (WAYS == 2) begin : g_pair
            // One bit names the least recently used way.
            logic lru_q;
            always_ff @(posedge clk) begin
                if (rst)
                    lru_q <= 1'b1;
                else if (upd_en)
                    lru_q <= age_d[1][0];
            end
            always_comb begin
                age_q[0] = AW'(~lru_q);
                age_q[1] = AW'(lru_q);
            end
        end else begin : g_wide
            logic [WAYS-1:0][AW-1:0] age_r;
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int w = 0; w < WAYS; w++)
                        age_r[w] <= AW'(w);
                end else if (upd_en) begin
                    age_r <= age_d;
                end
            end
            assign age_q = age_r;
        end
    endgenerate

    logic [WAYS-1:0] seen;
    always_comb begin
        seen = '0;
        for (int w = 0; w < WAYS; w++)
            seen[age_q[w]] = 1'b1;
    end

    // R8: stored ages never collide.
    assert_ages_permutation_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(seen) == WAYS);

endmodule

// File: rtl/age_lru_set.sv
module age_lru_set
    import lru_pkg::*;
#(
    parameter int WAYS = 4,
    localparam int AW  = idx_width(WAYS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            touch_valid,
    input  logic [AW-1:0]   touch_way,
    input  logic            fill_req,
    input  logic [WAYS-1:0] way_valid,
    output logic [AW-1:0]   victim_way
);
    localparam logic [AW-1:0] OLDEST = AW'(WAYS - 1);

    logic [WAYS-1:0][AW-1:0] age_q;
    logic [WAYS-1:0][AW-1:0] age_d;
    logic                    upd_en;
    upd_kind_e               kind;

    assign kind = pick_kind(touch_valid, fill_req);

    lru_age_victim #(.WAYS(WAYS), .AW(AW)) u_victim (
        .clk       (clk),
        .rst       (rst),
        .age_q     (age_q),
        .way_valid (way_valid),
        .victim    (victim_way)
    );

    lru_age_update #(.WAYS(WAYS), .AW(AW)) u_update (
        .age_q     (age_q),
        .kind      (kind),
        .touch_way (touch_way),
        .victim    (victim_way),
        .upd_en    (upd_en),
        .age_d     (age_d)
    );

    lru_age_store #(.WAYS(WAYS), .AW(AW)) u_store (
        .clk    (clk),
        .rst    (rst),
        .upd_en (upd_en),
        .age_d  (age_d),
        .age_q  (age_q)
    );

    // Checker state: the update seen at the previous edge.
    upd_kind_e     chk_kind_q;
    logic [AW-1:0] chk_way_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_kind_q <= UPD_NONE;
            chk_way_q  <= '0;
        end else begin
            chk_kind_q <= kind;
            chk_way_q  <= fill_req ? victim_way : touch_way;
        end
    end

    // R4: a touched way is youngest afterwards.
    assert_touch_mru_R4: assert property (@(posedge clk) disable iff (rst)
        (chk_kind_q == UPD_TOUCH) |-> (age_q[chk_way_q] == '0));

    // R5, R6: the filled victim (chosen before the edge) is youngest afterwards.
    assert_fill_mru_R5: assert property (@(posedge clk) disable iff (rst)
        (chk_kind_q == UPD_FILL) |-> (age_q[chk_way_q] == '0));

    // R3: with every way valid, the victim is the oldest way.
    assert_victim_oldest_R3: assert property (@(posedge clk) disable iff (rst)
        (&way_valid) |-> (age_q[victim_way] == OLDEST));

    // R7: without strobes and with stable valid bits, the victim holds.
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!touch_valid && !fill_req) |=> (!$stable(way_valid) || $stable(victim_way)));

endmodule

// File: tb/tb_age_lru_set.sv
module tb_age_lru_set;
    localparam int CLK_PERIOD = 10;
    localparam int WAYS = 4;
    localparam int AW = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            touch_valid = 1'b0;
    logic [AW-1:0]   touch_way = '0;
    logic            fill_req = 1'b0;
    logic [WAYS-1:0] way_valid = '1;
    logic [AW-1:0]   victim_way;

    logic       p_touch = 1'b0;
    logic       p_way = 1'b0;
    logic       p_fill = 1'b0;
    logic [1:0] p_valid = 2'b11;
    logic       p_victim;

    always #(CLK_PERIOD / 2) clk = ~clk;

    age_lru_set #(.WAYS(WAYS)) dut (
        .clk(clk), .rst(rst), .touch_valid(touch_valid), .touch_way(touch_way),
        .fill_req(fill_req), .way_valid(way_valid), .victim_way(victim_way)
    );

    age_lru_set #(.WAYS(2)) dut_pair (
        .clk(clk), .rst(rst), .touch_valid(p_touch), .touch_way(p_way),
        .fill_req(p_fill), .way_valid(p_valid), .victim_way(p_victim)
    );

    typedef struct {
        int    exp;
        string req;
    } exp_item_t;

    exp_item_t exp_q[$];
    int        order[$];
    int        checks = 0;
    int        failures = 0;
    event      chk_ev;

    // Reference order: front = most recently used.
    function automatic void promote(input int w);
        foreach (order[i]) begin
            if (order[i] == w) begin
                order.delete(i);
                break;
            end
        end
        order.push_front(w);
    endfunction

    function automatic int model_victim(input logic [WAYS-1:0] v);
        for (int w = 0; w < WAYS; w++)
            if (!v[w]) return w;
        return order[$];
    endfunction

    // Monitor: compare the settled victim with the expected item.
    initial begin
        forever begin
            @(chk_ev);
            #1;
            if (exp_q.size() > 0) begin
                exp_item_t it;
                it = exp_q.pop_front();
                checks++;
                if (int'(victim_way) != it.exp) begin
                    failures++;
                    $display("FAIL %s: victim_way actual=%0d expected=%0d", it.req, victim_way, it.exp);
                end
            end
        end
    end

    // Driver: apply one cycle of stimulus, queue its expected victim, advance the model.
    task automatic step(input bit t, input int tw, input bit f, input logic [WAYS-1:0] v,
                        input string req);
        int e;
        @(negedge clk);
        touch_valid = t;
        touch_way   = AW'(tw);
        fill_req    = f;
        way_valid   = v;
        e = model_victim(v);
        exp_q.push_back('{exp: e, req: req});
        -> chk_ev;
        @(posedge clk);
        if (f)
            promote(e);
        else if (t)
            promote(tw);
    endtask

    task automatic pair_check(input int exp, input string req);
        #1;
        checks++;
        if (int'(p_victim) != exp) begin
            failures++;
            $display("FAIL %s: pair victim actual=%0d expected=%0d", req, p_victim, exp);
        end
    endtask

    task automatic pair_step(input bit t, input bit w, input bit f);
        @(negedge clk);
        p_touch = t; p_way = w; p_fill = f;
        @(negedge clk);
        p_touch = 1'b0; p_fill = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        for (int w = 0; w < WAYS; w++) order.push_back(w);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset order 0 youngest .. 3 oldest.
        step(0, 0, 0, 4'hF, "R1");
        // R2: invalid ways take precedence, lowest index first.
        step(0, 0, 0, 4'b1011, "R2");
        step(0, 0, 0, 4'b0000, "R2");
        step(0, 0, 0, 4'b1100, "R2");
        // R4: touches reorder; untouched ways keep their order.
        step(1, 3, 0, 4'hF, "R4");
        step(1, 1, 0, 4'hF, "R4");
        step(1, 2, 0, 4'hF, "R4");
        step(0, 0, 0, 4'hF, "R3");
        // R5: fill of the oldest way, then fill into an invalid way.
        step(0, 0, 1, 4'hF, "R5");
        step(0, 0, 0, 4'hF, "R5");
        step(0, 0, 1, 4'b1101, "R5");
        step(0, 0, 0, 4'hF, "R5");
        // R6: touch and fill together; only the fill acts.
        step(1, 0, 1, 4'hF, "R6");
        step(0, 0, 0, 4'hF, "R6");
        step(1, 0, 1, 4'hF, "R6");
        step(0, 0, 0, 4'hF, "R6");
        // R7: idle cycles hold the order.
        for (int i = 0; i < 4; i++) step(0, 0, 0, 4'hF, "R7");
        // R8: mixed traffic against the reference order.
        for (int i = 0; i < 400; i++) begin
            bit t;
            bit f;
            logic [WAYS-1:0] v;
            t = 1'($urandom % 2);
            f = ($urandom % 4) == 0;
            v = (($urandom % 3) == 0) ? 4'($urandom) : 4'hF;
            step(t, int'($urandom % WAYS), f, v, "R8_mix");
        end
        @(negedge clk);
        touch_valid = 1'b0;
        fill_req = 1'b0;

        // R9: two-way single-bit state.
        pair_check(1, "R9_reset");
        pair_step(1, 1'b1, 1'b0);
        pair_check(0, "R9_touch1");
        pair_step(1, 1'b0, 1'b0);
        pair_check(1, "R9_touch0");
        pair_step(0, 1'b0, 1'b1);
        pair_check(0, "R9_fill");
        @(negedge clk);
        p_valid = 2'b01;
        pair_check(1, "R9_invalid");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule